// File: doc/BRIEF.md
# UART Channel Interrupt Identifier

This block is the interrupt logic of a single UART channel. It gathers seven interrupt sources and picks one of them by a fixed seven-level priority. Five sources are event-driven: receive line error, receive character timeout, modem-status change, received flow-control or special character, and flow-control pin change. Two sources are level-driven: the receive FIFO trigger and the transmit FIFO trigger. The block encodes the winning source into an 8-bit interrupt status value and drives an active-high interrupt line.

Each event source is held in a sticky flag until its clear strobe arrives. The surrounding UART creates these strobes from its register-read side effects. The two FIFO sources follow the FIFO counts and the trigger levels. Callers pass the trigger levels in as resolved integers from 1 to 64. Each source has its own enable bit. All outputs come from registered state, so any change on the inputs appears on the outputs one clock later.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held, and after reset with no input activity, isr_o reads 0x01 and irq_o is low.
- R2: isr_o[0] is 0 exactly when some source is pending. irq_o is high exactly when isr_o[0] is 0.
- R3: isr_o[7:6] reads 2'b11 one cycle after fifo_en_i is high, and 2'b00 one cycle after it is low.
- R4: isr_o[5:0] codes for the top four priority levels are as follows:
  - level 1, line error (evt_i[0]): 0x06
  - level 2, receive trigger: 0x04
  - level 3, receive timeout (evt_i[1]): 0x0C
  - level 4, transmit trigger: 0x02
- R5: isr_o[5:0] codes for the lower three levels are as follows:
  - level 5, modem change (evt_i[2]): 0x00
  - level 6, flow-control or special character (evt_i[3]): 0x10
  - level 7, pin change (evt_i[4]): 0x20
- R6: When several sources are pending, only the one with the lowest level number is encoded. Level 1 is the highest priority.
- R7: The receive trigger is pending while rx_cnt_i >= rx_lvl_i with the FIFOs enabled. With the FIFOs disabled, it is pending while rx_cnt_i >= 1.
- R8: The block arms the transmit trigger when tx_cnt_i exceeds the transmit level. Once armed, the trigger is pending as soon as tx_cnt_i falls below the level. With the FIFOs disabled, the level is 1.
- R9: The transmit trigger is pending whenever tx_cnt_i is 0. The block disarms it when the count reaches 0. A count that stays at or below the level without arming gives no interrupt until the FIFO is empty.
- R10: An event flag, once set by its evt_i bit, stays pending until its clr_i bit (same bit position) is pulsed. If set and clear arrive in the same cycle, the set wins.
- R11: Each en_i bit k gates priority level k+1. A disabled source never appears in isr_o. Disabling an event source discards its pending flag.
- R12: Every input change is reflected on isr_o and irq_o exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFO mode enable |
| en_i | input | 7 | Per-level source enable; bit k is level k+1 |
| evt_i | input | 5 | Event pulses: line error, timeout, modem, special char, pin change |
| clr_i | input | 5 | Clear strobes, same bit order as evt_i |
| rx_cnt_i | input | CNT_W | Receive FIFO character count |
| tx_cnt_i | input | CNT_W | Transmit FIFO character count |
| rx_lvl_i | input | CNT_W | Resolved receive trigger level (1..64) |
| tx_lvl_i | input | CNT_W | Resolved transmit trigger level (1..64) |
| isr_o | output | 8 | Interrupt status value |
| irq_o | output | 1 | Interrupt line, high while a source is pending |

## Verification
The bound checker watches several behaviours on every cycle:
- the FIFO-mode bits;
- the line-error source taking the top code one cycle after its event;
- line error vanishing from the output when its enable is low;
- a held line-error flag surviving cycles without a clear;
- a met receive trigger producing the receive code when level 1 is off;
- the encoded code always belonging to the legal set.

Some behaviours depend on the history of the transmit count, and only the bench's directed sequences can show them. These are the transmit arming and disarming across a reload, the full priority ladder as sources are cleared one by one, and the FIFO-disabled fallback of both trigger levels.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned N_LEVELS = 7;
  localparam int unsigned N_STICKY = 5;

  typedef enum logic [2:0] {
    LV_LINE   = 3'd0,
    LV_RXTRIG = 3'd1,
    LV_RXTO   = 3'd2,
    LV_TXTRIG = 3'd3,
    LV_MODEM  = 3'd4,
    LV_SPCHR  = 3'd5,
    LV_PINCHG = 3'd6
  } irq_level_e;

  localparam logic [5:0] NONE_CODE = 6'h01;

  function automatic logic [5:0] level_code(input int unsigned lv);
    logic [5:0] c;
    case (lv)
      0:       c = 6'h06;
      1:       c = 6'h04;
      2:       c = 6'h0C;
      3:       c = 6'h02;
      4:       c = 6'h00;
      5:       c = 6'h10;
      6:       c = 6'h20;
      default: c = NONE_CODE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_d;
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_comb begin
      if (!en_i[k]) begin
        flag_d[k] = 1'b0;
      end else if (set_i[k]) begin
        flag_d[k] = 1'b1;
      end else if (clr_i[k]) begin
        flag_d[k] = 1'b0;
      end else begin
        flag_d[k] = flag_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else begin
        flag_q[k] <= flag_d[k];
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_fifo_cond.sv
module irq_fifo_cond #(
  parameter int unsigned CNT_W = 7,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lvl_i,
  output logic             cond_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] eff_lvl;
  logic             cond_d;
  logic             cond_q;

  assign eff_lvl = fifo_en_i ? lvl_i : ONE;

  if (IS_TX) begin : g_tx
    logic armed_d;
    logic armed_q;
    logic empty;

    assign empty = (cnt_i == '0);

    always_comb begin
      if (empty) begin
        armed_d = 1'b0;
      end else if (cnt_i > eff_lvl) begin
        armed_d = 1'b1;
      end else begin
        armed_d = armed_q;
      end
      cond_d = empty || (armed_q && (cnt_i < eff_lvl));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b0;
      end else begin
        armed_q <= armed_d;
      end
    end
  end else begin : g_rx
    always_comb begin
      cond_d = (cnt_i >= eff_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
    end
  end

  assign cond_o = cond_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = N_LEVELS
) (
  input  logic [N-1:0] pend_i,
  output logic [5:0]   code_o
);

  always_comb begin
    code_o = NONE_CODE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = level_code(i);
      end
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic [6:0]       en_i,
  input  logic [4:0]       evt_i,
  input  logic [4:0]       clr_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_lvl_i,
  input  logic [CNT_W-1:0] tx_lvl_i,
  output logic [7:0]       isr_o,
  output logic             irq_o
);

  logic [N_STICKY-1:0] st_en;
  logic [N_STICKY-1:0] st_flag;
  logic                rx_cond;
  logic                tx_cond;
  logic [N_LEVELS-1:0] en_q;
  logic                fifo_en_q;
  logic [N_LEVELS-1:0] pend;
  logic [5:0]          code;

  assign st_en = {en_i[LV_PINCHG], en_i[LV_SPCHR], en_i[LV_MODEM],
                  en_i[LV_RXTO], en_i[LV_LINE]};

  irq_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (st_en),
    .set_i  (evt_i),
    .clr_i  (clr_i),
    .flag_o (st_flag)
  );

  irq_fifo_cond #(.CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_i (fifo_en_i),
    .cnt_i     (rx_cnt_i),
    .lvl_i     (rx_lvl_i),
    .cond_o    (rx_cond)
  );

  irq_fifo_cond #(.CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_i (fifo_en_i),
    .cnt_i     (tx_cnt_i),
    .lvl_i     (tx_lvl_i),
    .cond_o    (tx_cond)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      fifo_en_q <= 1'b0;
    end else begin
      en_q      <= en_i;
      fifo_en_q <= fifo_en_i;
    end
  end

  always_comb begin
    pend            = '0;
    pend[LV_LINE]   = st_flag[0];
    pend[LV_RXTRIG] = rx_cond;
    pend[LV_RXTO]   = st_flag[1];
    pend[LV_TXTRIG] = tx_cond;
    pend[LV_MODEM]  = st_flag[2];
    pend[LV_SPCHR]  = st_flag[3];
    pend[LV_PINCHG] = st_flag[4];
    pend            = pend & en_q;
  end

  irq_prio_enc #(.N(N_LEVELS)) u_enc (
    .pend_i (pend),
    .code_o (code)
  );

  assign isr_o = {{2{fifo_en_q}}, code};
  assign irq_o = |pend;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en_i,
  input logic [6:0]       en_i,
  input logic [4:0]       evt_i,
  input logic [4:0]       clr_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic [CNT_W-1:0] rx_lvl_i,
  input logic [7:0]       isr_o,
  input logic             irq_o
);

  a_r3_fifo_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en_i |=> isr_o[7:6] == 2'b11);

  a_r3_fifo_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en_i |=> isr_o[7:6] == 2'b00);

  a_r6_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i[0] && evt_i[0]) |=> (isr_o[5:0] == 6'h06 && irq_o));

  a_r11_line_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[0] |=> isr_o[5:0] != 6'h06);

  a_r10_line_held: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_o[5:0] == 6'h06 && en_i[0] && !clr_i[0]) |=> isr_o[5:0] == 6'h06);

  a_r7_rx_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i[0] && en_i[1] && fifo_en_i && (rx_cnt_i >= rx_lvl_i))
      |=> isr_o[5:0] == 6'h04);

  always_comb begin
    if (rst_n) begin
      a_r2_legal_code: assert (isr_o[5:0] inside {6'h01, 6'h06, 6'h04, 6'h0C,
                                                 6'h02, 6'h00, 6'h10, 6'h20});
    end
  end

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fifo_en_i (fifo_en_i),
  .en_i      (en_i),
  .evt_i     (evt_i),
  .clr_i     (clr_i),
  .rx_cnt_i  (rx_cnt_i),
  .rx_lvl_i  (rx_lvl_i),
  .isr_o     (isr_o),
  .irq_o     (irq_o)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int unsigned CW = 7;

  logic          clk;
  logic          rst_n;
  logic          fifo_en;
  logic [6:0]    en;
  logic [4:0]    evt;
  logic [4:0]    clr;
  logic [CW-1:0] rx_cnt;
  logic [CW-1:0] tx_cnt;
  logic [CW-1:0] rx_lvl;
  logic [CW-1:0] tx_lvl;
  logic [7:0]    isr;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_irq_ident #(.CNT_W(CW)) u_uart_irq_ident (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_i (fifo_en),
    .en_i      (en),
    .evt_i     (evt),
    .clr_i     (clr),
    .rx_cnt_i  (rx_cnt),
    .tx_cnt_i  (tx_cnt),
    .rx_lvl_i  (rx_lvl),
    .tx_lvl_i  (tx_lvl),
    .isr_o     (isr),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp_isr);
    logic exp_irq;
    exp_irq = ~exp_isr[0];
    checks++;
    if (isr !== exp_isr || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: isr=%02h irq=%0b expected isr=%02h irq=%0b",
               req, isr, irq, exp_isr, exp_irq);
    end
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    evt = v;
    step();
    evt = '0;
  endtask

  task automatic pulse_clr(input logic [4:0] v);
    clr = v;
    step();
    clr = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fifo_en = 1'b0; en = '0; evt = '0; clr = '0;
    rx_cnt = '0; tx_cnt = 7'd10; rx_lvl = 7'd1; tx_lvl = 7'd1;
    step();
    chk("R1 in reset", 8'h01);
    rst_n = 1'b1;
    step(); step();
    chk("R1 after reset idle", 8'h01);
  endtask

  task automatic t_fifo_bits();
    fifo_en = 1'b1;
    step();
    chk("R3 fifo enabled bits", 8'hC1);
    fifo_en = 1'b0;
    step();
    chk("R3 fifo disabled bits", 8'h01);
    fifo_en = 1'b1;
    step();
  endtask

  task automatic t_codes_single();
    en = 7'h7F;
    step();
    pulse_evt(5'b00001); chk("R4 line error code", 8'hC6);  pulse_clr(5'b00001);
    pulse_evt(5'b00010); chk("R4 timeout code", 8'hCC);     pulse_clr(5'b00010);
    pulse_evt(5'b00100); chk("R5 modem code", 8'hC0);       pulse_clr(5'b00100);
    pulse_evt(5'b01000); chk("R5 special char code", 8'hD0); pulse_clr(5'b01000);
    pulse_evt(5'b10000); chk("R5 pin change code", 8'hE0);  pulse_clr(5'b10000);
    chk("R2 none pending after clears", 8'hC1);
  endtask

  task automatic t_ladder();
    rx_cnt = 7'd1;
    pulse_evt(5'b11111);
    chk("R6 all pending -> level 1", 8'hC6);
    pulse_clr(5'b00001);
    chk("R6 level 2 next", 8'hC4);
    rx_cnt = 7'd0;
    step();
    chk("R6 level 3 next", 8'hCC);
    pulse_clr(5'b00010);
    chk("R6 level 5 next", 8'hC0);
    tx_cnt = 7'd0;
    step();
    chk("R6 level 4 beats 5", 8'hC2);
    tx_cnt = 7'd10;
    step();
    pulse_clr(5'b00100);
    chk("R6 level 6 next", 8'hD0);
    pulse_clr(5'b01000);
    chk("R6 level 7 next", 8'hE0);
    pulse_clr(5'b10000);
    chk("R6 ladder empty", 8'hC1);
  endtask

  task automatic t_rx_trigger();
    rx_lvl = 7'd8; rx_cnt = 7'd7;
    step();
    chk("R7 below rx level", 8'hC1);
    rx_cnt = 7'd8;
    step();
    chk("R7 at rx level", 8'hC4);
    fifo_en = 1'b0; rx_cnt = 7'd1;
    step();
    chk("R7 fifo off level 1", 8'h04);
    rx_cnt = 7'd0; fifo_en = 1'b1; rx_lvl = 7'd1;
    step();
    chk("R7 rx idle", 8'hC1);
  endtask

  task automatic t_tx_trigger();
    tx_lvl = 7'd4; tx_cnt = 7'd8;
    step();
    chk("R8 reload above level", 8'hC1);
    tx_cnt = 7'd3;
    step();
    chk("R8 fell below level", 8'hC2);
    tx_cnt = 7'd0;
    step();
    chk("R9 empty pending", 8'hC2);
    tx_cnt = 7'd2;
    step();
    chk("R9 low reload no irq", 8'hC1);
    tx_cnt = 7'd1;
    step();
    chk("R9 drain unarmed no irq", 8'hC1);
    tx_cnt = 7'd0;
    step();
    chk("R9 unarmed empty fires", 8'hC2);
    tx_cnt = 7'd10;
    step();
    fifo_en = 1'b0; tx_cnt = 7'd3;
    step();
    chk("R8 fifo off level 1 no irq", 8'h01);
    tx_cnt = 7'd0;
    step();
    chk("R8 fifo off empty", 8'h02);
    fifo_en = 1'b1; tx_lvl = 7'd1; tx_cnt = 7'd10;
    step();
    chk("R8 tx idle", 8'hC1);
  endtask

  task automatic t_sticky();
    pulse_evt(5'b00001);
    step(); step();
    chk("R10 flag held", 8'hC6);
    evt = 5'b00001; clr = 5'b00001;
    step();
    evt = '0; clr = '0;
    chk("R10 set wins over clear", 8'hC6);
    pulse_clr(5'b00001);
    chk("R10 cleared", 8'hC1);
  endtask

  task automatic t_enables();
    en = 7'h7E;
    pulse_evt(5'b00001);
    chk("R11 disabled line error ignored", 8'hC1);
    en = 7'h7F;
    pulse_evt(5'b00001);
    chk("R11 enabled line error", 8'hC6);
    en = 7'h7E;
    step();
    chk("R11 disable hides flag", 8'hC1);
    en = 7'h7F;
    step();
    chk("R11 flag discarded", 8'hC1);
    en = 7'h7D; rx_cnt = 7'd5;
    step();
    chk("R11 rx trigger gated", 8'hC1);
    rx_cnt = 7'd0; en = 7'h7F;
    step();
  endtask

  task automatic t_latency();
    evt = 5'b00100;
    #1;
    chk("R12 no change before edge", 8'hC1);
    @(posedge clk); #1;
    evt = '0;
    chk("R12 change after one edge", 8'hC0);
    @(negedge clk);
    pulse_clr(5'b00100);
    chk("R12 cleared", 8'hC1);
  endtask

  initial begin
    t_reset();
    t_fifo_bits();
    t_codes_single();
    t_ladder();
    t_rx_trigger();
    t_tx_trigger();
    t_sticky();
    t_enables();
    t_latency();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule